// File: doc/BRIEF.md
# SPI Memory Write-Protection Controller

This block holds the protection and status logic for the slave side of a serial nonvolatile memory, SPI mode 0. It runs on a fast system clock. Chip select, serial clock, serial input and the write-protect pin are treated as synchronous to that clock, and each must stay stable for at least two system clock cycles per level. The block shifts in an 8-bit command, MSB first, on rising serial-clock edges. It keeps a write-enable latch and a small status register. The status register holds a protect-enable flag and a 2-bit block-protect code.

Every write attempt goes through one gate. A write needs the enable latch to be set, and its address must lie outside the protected upper part of the 17-bit array. A write to the status register is also refused while protect-enable is set and the write-protect pin was low when the command began. Array writes that pass appear as one-cycle strobes with an address and a data byte. The status register can be read back MSB first on the serial output. The array itself is outside this block.

Top module: `spi_wprot_ctrl`

## Requirements
- R1: After reset the enable latch, protect-enable and block-protect code are all 0. A status read returns 0x00, and so_oe is low.
- R2: Command 0x06 sets the enable latch, and command 0x04 clears it. In both cases the change takes effect when chip select rises after the command.
- R3: Command 0x01 (status write) and command 0x02 (array write) are write-class. If one arrives while the enable latch is 0, it is ignored, and every later bit in that same select period is ignored as well. That includes further opcodes and data.
- R4: When an accepted write-class command ends, at the chip-select rise, the enable latch clears to 0. This happens even if the data was refused by protection. A further write then needs a new 0x06.
- R5: The block-protect code decides which array addresses are protected. Code 0 protects none. Code 1 protects 0x18000–0x1FFFF. Code 2 protects 0x10000–0x1FFFF. Code 3 protects every address. Data bytes aimed at protected addresses produce no strobe, whatever the enable latch and write-protect pin are doing.
- R6: An array write is sent as opcode 0x02, then three address bytes MSB first, then any number of data bytes. Only the low 17 address bits are used. The address goes up by one after each data byte and wraps from 0x1FFFF to 0x00000. Protection is checked separately for each byte's address.
- R7: A status write takes one data byte. It is refused when protect-enable is 1 and the write-protect pin is low. When protect-enable is 0, the pin has no effect.
- R8: The write-protect pin is sampled only when chip select falls. Later changes to the pin during the same select period do not affect that command.
- R9: Status byte layout: bit 7 is protect-enable, bits 3:2 are the block-protect code, and bit 1 is the enable latch. All other bits read 0. A status write updates only bits 7 and 3:2.
- R10: After opcode 0x05, the status byte is driven on so, MSB first, changing on falling serial-clock edges. so_oe is high only during such a read while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; low means high impedance |
| wr_stb | output | 1 | One-cycle strobe for a granted array write |
| wr_addr | output | 17 | Array address for the granted write |
| wr_data | output | 8 | Data byte for the granted write |

## Verification
Most internal faults in this block become visible at the ports on the next status read. A wrong enable latch or protection code shows up in the status byte on the very next 0x05 command. A wrong grant decision shows up at the strobe port within one system cycle of the eighth data bit. The bench therefore reads the status after every state-changing command. It also sweeps all four protect codes against addresses on both sides of each range boundary, so an off-by-one in the range compare shows up as a missing or extra strobe.

// File: rtl/spi_wprot_ctrl.sv
module spi_wprot_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int ADR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              wp_n,
  output logic              so,
  output logic              so_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int BC_W = (ADR_BYTES > 1) ? $clog2(ADR_BYTES) : 1;

  typedef enum logic [2:0] {S_OP, S_ADR, S_DAT, S_SRW, S_RD, S_SKIP} st_t;

  st_t              state;
  logic             sck_q, cs_q;
  logic [2:0]       bitcnt;
  logic [BC_W-1:0]  bytecnt;
  logic [6:0]       sh;
  logic [ADDR_W-1:0] addr;
  logic             wen, wen_set, wen_clr;
  logic             wpen, wp_lock;
  logic [1:0]       bp;
  logic [7:0]       tx;
  logic             so_q;

  wire sck_rise  = sck & ~sck_q & ~cs_n;
  wire sck_fall  = ~sck & sck_q & ~cs_n;
  wire cs_fall   = ~cs_n & cs_q;
  wire cs_rise   = cs_n & ~cs_q;
  wire byte_done = sck_rise && (bitcnt == 3'd7);
  wire [7:0] byte_in = {sh, si};
  wire [7:0] status  = {wpen, 3'b000, bp, wen, 1'b0};

  function automatic logic prot(input logic [1:0] code, input logic [ADDR_W-1:0] a);
    case (code)
      2'd0:    prot = 1'b0;
      2'd1:    prot = (a[ADDR_W-1 -: 2] == 2'b11);
      2'd2:    prot = a[ADDR_W-1];
      default: prot = 1'b1;
    endcase
  endfunction

  assign so    = so_q;
  assign so_oe = (state == S_RD) & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OP; sck_q <= 1'b0; cs_q <= 1'b1;
      bitcnt <= '0; bytecnt <= '0; sh <= '0; addr <= '0;
      wen <= 1'b0; wen_set <= 1'b0; wen_clr <= 1'b0;
      wpen <= 1'b0; wp_lock <= 1'b0; bp <= 2'b00;
      tx <= '0; so_q <= 1'b0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      sck_q  <= sck;
      cs_q   <= cs_n;
      wr_stb <= 1'b0;
      if (cs_fall) wp_lock <= wpen & ~wp_n;
      if (cs_n) begin
        state <= S_OP; bitcnt <= '0; bytecnt <= '0;
        if (cs_rise) begin
          if (wen_set) wen <= 1'b1;
          if (wen_clr) wen <= 1'b0;
        end
        wen_set <= 1'b0;
        wen_clr <= 1'b0;
      end else begin
        if (sck_rise) begin
          sh     <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (sck_fall && state == S_RD) begin
          so_q <= tx[7];
          tx   <= {tx[6:0], tx[7]};
        end
        if (byte_done) begin
          case (state)
            S_OP: begin
              state <= S_SKIP;
              case (byte_in)
                8'h06: wen_set <= 1'b1;
                8'h04: wen_clr <= 1'b1;
                8'h05: begin state <= S_RD; tx <= status; end
                8'h01: if (wen) begin state <= S_SRW; wen_clr <= 1'b1; end
                8'h02: if (wen) begin state <= S_ADR; wen_clr <= 1'b1; bytecnt <= '0; end
                default: ;
              endcase
            end
            S_ADR: begin
              addr    <= {addr[ADDR_W-9:0], byte_in};
              bytecnt <= bytecnt + 1'b1;
              if (bytecnt == BC_W'(ADR_BYTES-1)) state <= S_DAT;
            end
            S_DAT: begin
              if (!prot(bp, addr)) begin
                wr_stb  <= 1'b1;
                wr_addr <= addr;
                wr_data <= byte_in;
              end
              addr <= addr + 1'b1;
            end
            S_SRW: begin
              if (!wp_lock) begin
                wpen <= byte_in[7];
                bp   <= byte_in[3:2];
              end
              state <= S_SKIP;
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_stb_unprot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !prot(bp, wr_addr));

  p_stb_needs_wen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wen);

  p_wen_rise_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> ($past(cs_n) && !$past(cs_n, 2)));

  p_wen_fall_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wen) |-> ($past(cs_n) && !$past(cs_n, 2)));

  p_sr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && wp_lock) |=> $stable({wpen, bp}));

  p_oe_no_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !wr_stb);
endmodule

// File: tb/spi_wprot_ctrl_tb.sv
module spi_wprot_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, wr_stb;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;

  int n_cmp = 0, n_bad = 0, nlog = 0;
  logic [16:0] log_a [0:15];
  logic [7:0]  log_d [0:15];
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_wprot_ctrl dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .wp_n(wp_n), .so(so), .so_oe(so_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(negedge clk) if (wr_stb && nlog < 16) begin
    log_a[nlog] = wr_addr; log_d[nlog] = wr_data; nlog++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = b[i]; sck = 1'b0; tick(4);
      r[i] = so;
      sck = 1'b1; tick(4);
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; tick(2); endtask
  task automatic cs_hi(); sck = 1'b0; tick(2); cs_n = 1'b1; tick(4); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xbyte(op, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xbyte(8'h05, d);
    chk(so_oe === 1'b1, "R10 oe during read", so_oe, 1);
    xbyte(8'h00, v); cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xbyte(8'h01, d); xbyte(v, d); cs_hi();
  endtask

  task automatic wr1(input logic [16:0] a, input logic [7:0] v);
    logic [7:0] d;
    nlog = 0;
    cs_lo(); xbyte(8'h02, d);
    xbyte({7'h7F, a[16]}, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    xbyte(v, d); cs_hi();
  endtask

  task automatic expect_sr(input logic [7:0] e, input string req);
    logic [7:0] v;
    rdsr(v);
    chk(v === e, req, v, e);
  endtask

  function automatic bit is_prot(input int code, input int a);
    if (code == 0) return 0;
    if (code == 1) return a >= 'h18000;
    if (code == 2) return a >= 'h10000;
    return 1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int alist [8] = '{'h00000, 'h0FFFF, 'h10000, 'h17FFF, 'h18000, 'h1ABCD, 'h1FFFF, 'h05555};
    logic [7:0] d;
    tick(4); rst_n = 1'b1; tick(4);

    chk(so_oe === 1'b0, "R1 so_oe after reset", so_oe, 0);
    expect_sr(8'h00, "R1 status after reset");

    wr1(17'h00100, 8'h5A);
    chk(nlog == 0, "R3 array write without enable", nlog, 0);

    cs_lo(); xbyte(8'h01, d); xbyte(8'h06, d); xbyte(8'h8C, d); cs_hi();
    expect_sr(8'h00, "R3 ignored until deselect");

    cs_lo(); xbyte(8'h06, d);
    chk(so_oe === 1'b0, "R10 oe low outside read", so_oe, 0);
    cs_hi();
    expect_sr(8'h02, "R2 enable set");
    cmd1(8'h04);
    expect_sr(8'h00, "R2 enable cleared");
    cmd1(8'h06); cmd1(8'h04);
    wr1(17'h00200, 8'h11);
    chk(nlog == 0, "R2 write after disable", nlog, 0);

    cmd1(8'h06);
    nlog = 0;
    cs_lo(); xbyte(8'h02, d); xbyte(8'hFF, d); xbyte(8'hFF, d); xbyte(8'hFE, d);
    xbyte(8'hA1, d); xbyte(8'hB2, d); xbyte(8'hC3, d); cs_hi();
    chk(nlog == 3, "R6 burst strobe count", nlog, 3);
    chk(log_a[0] == 17'h1FFFE && log_d[0] == 8'hA1, "R6 burst byte0", log_a[0], 'h1FFFE);
    chk(log_a[1] == 17'h1FFFF && log_d[1] == 8'hB2, "R6 burst byte1", log_a[1], 'h1FFFF);
    chk(log_a[2] == 17'h00000 && log_d[2] == 8'hC3, "R6 burst wrap", log_a[2], 0);
    expect_sr(8'h00, "R4 auto clear after write");
    wr1(17'h00300, 8'h22);
    chk(nlog == 0, "R4 second write needs enable", nlog, 0);

    for (int code = 0; code < 4; code++) begin
      cmd1(8'h06);
      wrsr({1'b0, 3'b111, code[1:0], 2'b11});
      expect_sr({4'b0, code[1:0], 2'b00}, "R9 status layout");
      for (int k = 0; k < 8; k++) begin
        bit p;
        p = is_prot(code, alist[k]);
        cmd1(8'h06);
        wr1(alist[k][16:0], alist[k][7:0] ^ code[7:0]);
        chk(nlog == (p ? 0 : 1), "R5 grant by code", nlog, p ? 0 : 1);
        if (!p && nlog == 1)
          chk(log_a[0] == alist[k][16:0] && log_d[0] == (alist[k][7:0] ^ code[7:0]),
              "R5 granted addr/data", log_a[0], alist[k]);
      end
      expect_sr({4'b0, code[1:0], 2'b00}, "R4 enable cleared after sweep");
    end
    cmd1(8'h06); wrsr(8'h00);
    expect_sr(8'h00, "R9 clear status");

    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h84);
    expect_sr(8'h84, "R7 pin ignored when protect-enable 0");
    cmd1(8'h06); wrsr(8'h08);
    expect_sr(8'h84, "R7 status locked");
    cmd1(8'h06); wrsr(8'h00);
    expect_sr(8'h84, "R4 enable cleared after refused status write");
    wp_n = 1'b1;
    cmd1(8'h06); wrsr(8'h88);
    expect_sr(8'h88, "R7 unlocked with pin high");

    cmd1(8'h06);
    cs_lo(); xbyte(8'h01, d); wp_n = 1'b0; xbyte(8'h80, d); cs_hi();
    expect_sr(8'h80, "R8 pin fall mid-command ignored");

    cmd1(8'h06);
    cs_lo(); wp_n = 1'b1; xbyte(8'h01, d); xbyte(8'h0C, d); cs_hi();
    expect_sr(8'h80, "R8 pin low at select start locks");

    cmd1(8'h06); wrsr(8'h00);
    expect_sr(8'h00, "R7 unlock final");

    finish_run();
  end
endmodule